// File: doc/BRIEF.md
# Watchdog Timer with Second or Minute Units

The block is a watchdog down-counter that software programs through four byte-wide registers on a simple write/read strobe port. A 16-bit timeout value is loaded into the counter. The counter then decrements once per time unit. A configuration bit picks the unit: one second, taken straight from an external one-second tick, or one minute, made from that tick by an internal divide-by-60 counter. When the count runs out, a sticky expiry flag is set and stays set until software clears it. An interrupt line chosen by software is raised while the flag is set. If enabled, a keyboard-reset pulse and a power-good drop pulse are also emitted.

Software or peripheral activity keeps the timer alive. Rewriting the low byte of the value reloads the counter. A pulse on an enabled event input also reloads it; the events are a game-port read, a keyboard interrupt, a mouse interrupt and an infrared-receiver interrupt. A reload from the infrared input takes effect only after a programmable delay. Software can also force an immediate timeout. A value of zero leaves the timer stopped. An expired timer does not fire again until it is reloaded.

Top module: `wdog_unit_timer`

## Requirements
- R1: After reset, all four registers read 0x00, the timer is stopped, and `kbd_rst_o`, `pwr_drop_o` and `irq_o` are all low.
- R2: With configuration bit 7 set (second units) and a value N loaded, the expiry flag (control bit 0) is still clear after N-1 second ticks and is set by the N-th tick.
- R3: With configuration bit 7 clear (minute units), expiry takes N×60 second ticks. The divide-by-60 counter restarts on every reload, so a reload part-way through a minute restarts the full interval.
- R4: A write to the value low byte (index 0x73) loads the counter from {high byte register, written byte}. A write to the high byte (index 0x74) only stores the byte and does not touch the counter.
- R5: Loading a value of 0 stops the timer: no number of ticks sets the expiry flag.
- R6: A one-cycle pulse on `ev_game`, `ev_kbd` or `ev_mouse` reloads the counter from the stored value only if its enable bit is set (control bit 4, 5 or 6 in that order). A pulse whose bit is clear has no effect.
- R7: With control bit 7 set, a pulse on `ev_ir` reloads the counter IR_DELAY clock cycles later. Before then, the counter keeps running.
- R8: Writing control with bit 1 set forces an immediate timeout: the counter goes to 0 and the expiry flag is set. Bit 1 always reads back as 0.
- R9: The expiry flag is sticky. A control write with bit 0 at 0 clears it, and a control write with bit 0 at 1 leaves it unchanged. Control reads back as {enables[7:4], 00, 0, flag}.
- R10: On expiry, `kbd_rst_o` goes high for exactly PULSE_LEN (16) cycles if configuration bit 6 was set. `pwr_drop_o` does the same if configuration bit 4 was set. Both start the cycle after the expiring clock edge.
- R11: While the expiry flag is set, `irq_o[k]` is high, where k is configuration bits 3:0 and k is not 0. A selection of 0 drives no line, and no more than one line is ever high.
- R12: After expiry, the counter stays at zero and no further expiry occurs until a reload, even after software clears the flag.
- R13: A read strobe returns the addressed register on `reg_rdata` one cycle later. Unmapped indices read 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_sec | input | 1 | One-cycle pulse once per second |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 8 | Register index |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, valid the cycle after `reg_rd` |
| ev_ir | input | 1 | Infrared-receiver interrupt pulse |
| ev_mouse | input | 1 | Mouse interrupt pulse |
| ev_kbd | input | 1 | Keyboard interrupt pulse |
| ev_game | input | 1 | Game-port read pulse |
| kbd_rst_o | output | 1 | Keyboard-reset pulse on expiry |
| pwr_drop_o | output | 1 | Power-good drop pulse on expiry |
| irq_o | output | 16 | Timeout interrupt lines, one selected |

## Verification
The bound checker watches several rules on every cycle:
- At most one interrupt line is high, and none is high without the flag.
- The flag falls only right after a clearing control write.
- Every run-out of a non-zero count sets the flag.
- The count holds still when there is no tick, reload or forced timeout.
- A forced timeout lands in the next cycle.

Only the bench scenarios can show the exact tick counts:
- N ticks in second units, N×60 in minute units.
- The restart of the minute divider on a reload.
- The IR reload delay.
- The 16-cycle pulse width.
- That disabled events and a zero value leave the timer alone.

// File: rtl/wdog_unit_timer.sv
module wdog_unit_timer #(
  parameter int TICKS_PER_MIN = 60,
  parameter int PULSE_LEN = 16,
  parameter int IR_DELAY = 500000,
  parameter logic [7:0] A_CTRL = 8'h71,
  parameter logic [7:0] A_CFG = 8'h72,
  parameter logic [7:0] A_VLO = 8'h73,
  parameter logic [7:0] A_VHI = 8'h74
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick_sec,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [7:0]  reg_addr,
  input  logic [7:0]  reg_wdata,
  output logic [7:0]  reg_rdata,
  input  logic        ev_ir,
  input  logic        ev_mouse,
  input  logic        ev_kbd,
  input  logic        ev_game,
  output logic        kbd_rst_o,
  output logic        pwr_drop_o,
  output logic [15:0] irq_o
);
  localparam int DIV_W = $clog2(TICKS_PER_MIN);
  localparam int PLS_W = $clog2(PULSE_LEN + 1);
  localparam int IRD_W = $clog2(IR_DELAY + 1);

  logic [3:0]       ev_en_q;
  logic             stat_q;
  logic [7:0]       cfg_q;
  logic [15:0]      val_q;
  logic [15:0]      cnt_q;
  logic [DIV_W-1:0] div_q;
  logic [PLS_W-1:0] pls_q;
  logic             kr_arm_q, pg_arm_q;
  logic [IRD_W-1:0] ird_q;

  logic wr_ctrl, wr_cfg, wr_vlo, wr_vhi;
  logic force_to, ir_fire, ev_hit, reload, unit_tick, expire;
  logic [15:0] reload_val;

  assign wr_ctrl = reg_wr && reg_addr == A_CTRL;
  assign wr_cfg  = reg_wr && reg_addr == A_CFG;
  assign wr_vlo  = reg_wr && reg_addr == A_VLO;
  assign wr_vhi  = reg_wr && reg_addr == A_VHI;

  assign force_to   = wr_ctrl && reg_wdata[1];
  assign ir_fire    = ird_q == IRD_W'(1);
  assign ev_hit     = (ev_en_q[0] && ev_game) || (ev_en_q[1] && ev_kbd) ||
                      (ev_en_q[2] && ev_mouse) || ir_fire;
  assign reload     = wr_vlo || ev_hit;
  assign reload_val = wr_vlo ? {val_q[15:8], reg_wdata} : val_q;
  assign unit_tick  = tick_sec && (cfg_q[7] || div_q == DIV_W'(TICKS_PER_MIN - 1));
  assign expire     = force_to || (!reload && unit_tick && cnt_q == 16'd1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ev_en_q <= '0;
      stat_q  <= 1'b0;
      cfg_q   <= '0;
      val_q   <= '0;
    end else begin
      if (wr_ctrl) ev_en_q <= reg_wdata[7:4];
      if (wr_cfg)  cfg_q <= reg_wdata;
      if (wr_vlo)  val_q[7:0] <= reg_wdata;
      if (wr_vhi)  val_q[15:8] <= reg_wdata;
      if (expire) stat_q <= 1'b1;
      else if (wr_ctrl && !reg_wdata[0]) stat_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      div_q <= '0;
    end else begin
      if (force_to) cnt_q <= '0;
      else if (reload) cnt_q <= reload_val;
      else if (unit_tick && cnt_q != '0) cnt_q <= cnt_q - 16'd1;

      if (reload || force_to || cfg_q[7]) div_q <= '0;
      else if (tick_sec)
        div_q <= (div_q == DIV_W'(TICKS_PER_MIN - 1)) ? '0 : div_q + DIV_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ird_q <= '0;
    else if (!ev_en_q[3]) ird_q <= '0;
    else if (ev_ir) ird_q <= IRD_W'(IR_DELAY);
    else if (ird_q != '0) ird_q <= ird_q - IRD_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pls_q    <= '0;
      kr_arm_q <= 1'b0;
      pg_arm_q <= 1'b0;
    end else if (expire) begin
      pls_q    <= PLS_W'(PULSE_LEN);
      kr_arm_q <= cfg_q[6];
      pg_arm_q <= cfg_q[4];
    end else if (pls_q != '0) begin
      pls_q <= pls_q - PLS_W'(1);
    end
  end

  assign kbd_rst_o  = kr_arm_q && pls_q != '0;
  assign pwr_drop_o = pg_arm_q && pls_q != '0;

  for (genvar i = 0; i < 16; i++) begin : g_irq
    if (i == 0) begin : g_none
      assign irq_o[i] = 1'b0;
    end else begin : g_line
      assign irq_o[i] = stat_q && cfg_q[3:0] == 4'(i);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) reg_rdata <= '0;
    else if (reg_rd) begin
      case (reg_addr)
        A_CTRL:  reg_rdata <= {ev_en_q, 3'b000, stat_q};
        A_CFG:   reg_rdata <= cfg_q;
        A_VLO:   reg_rdata <= val_q[7:0];
        A_VHI:   reg_rdata <= val_q[15:8];
        default: reg_rdata <= 8'h00;
      endcase
    end
  end
endmodule

module wdog_unit_timer_chk #(
  parameter logic [7:0] A_CTRL = 8'h71
) (
  input logic        clk,
  input logic        rst_n,
  input logic        tick_sec,
  input logic        reg_wr,
  input logic [7:0]  reg_addr,
  input logic [7:0]  reg_wdata,
  input logic        kbd_rst_o,
  input logic        pwr_drop_o,
  input logic [15:0] irq_o,
  input logic        stat,
  input logic [15:0] cnt,
  input logic        reload,
  input logic        force_to
);
  // R11
  irq_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(irq_o));
  // R11
  irq_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n) !stat |-> irq_o == '0);
  // R10
  kbd_pulse_flag_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(kbd_rst_o) |-> stat);
  // R10
  pwr_pulse_flag_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(pwr_drop_o) |-> stat);
  // R9
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stat) |-> $past(reg_wr && reg_addr == A_CTRL && !reg_wdata[0]));
  // R2
  runout_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cnt) != '0 && cnt == '0 && !$past(reload)) |-> stat);
  // R12
  count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(tick_sec) && !$past(reload) && !$past(force_to)) |-> $stable(cnt));
  // R8
  force_chk: assert property (@(posedge clk) disable iff (!rst_n)
    force_to |=> (stat && cnt == '0));
endmodule

bind wdog_unit_timer wdog_unit_timer_chk #(.A_CTRL(A_CTRL)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick_sec(tick_sec), .reg_wr(reg_wr),
  .reg_addr(reg_addr), .reg_wdata(reg_wdata), .kbd_rst_o(kbd_rst_o),
  .pwr_drop_o(pwr_drop_o), .irq_o(irq_o), .stat(stat_q), .cnt(cnt_q),
  .reload(reload), .force_to(force_to)
);

// File: tb/test_wdog_unit_timer.sv
`timescale 1ns/1ps
module test_wdog_unit_timer;
  localparam logic [7:0] CT = 8'h71, CF = 8'h72, VL = 8'h73, VH = 8'h74;
  localparam int IRD = 8;

  logic clk = 0, rst_n = 0, tick_sec = 0, reg_wr = 0, reg_rd = 0;
  logic [7:0] reg_addr = 0, reg_wdata = 0, reg_rdata;
  logic ev_ir = 0, ev_mouse = 0, ev_kbd = 0, ev_game = 0;
  logic kbd_rst_o, pwr_drop_o;
  logic [15:0] irq_o;
  int total = 0, fails = 0;

  always #2 clk = ~clk;

  wdog_unit_timer #(.IR_DELAY(IRD)) i_wdog_unit_timer (
    .clk(clk), .rst_n(rst_n), .tick_sec(tick_sec), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .ev_ir(ev_ir), .ev_mouse(ev_mouse), .ev_kbd(ev_kbd), .ev_game(ev_game),
    .kbd_rst_o(kbd_rst_o), .pwr_drop_o(pwr_drop_o), .irq_o(irq_o));

  typedef struct { logic [7:0] v; string tag; } item_t;
  item_t sb_q[$];
  logic rd_q = 0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  always @(posedge clk) rd_q <= reg_rd;
  always @(negedge clk) begin
    if (rd_q && sb_q.size() > 0) begin
      item_t it;
      it = sb_q.pop_front();
      check(it.tag, {24'h0, reg_rdata}, {24'h0, it.v});
    end
  end

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd_exp(input logic [7:0] a, input logic [7:0] e, input string tag);
    item_t it;
    it.v = e; it.tag = tag;
    @(negedge clk); reg_rd = 1; reg_addr = a; sb_q.push_back(it);
    @(negedge clk); reg_rd = 0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick_sec = 1;
      @(negedge clk); tick_sec = 0;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    check("R1 kbd", kbd_rst_o, 0);
    check("R1 pwr", pwr_drop_o, 0);
    check("R1 irq", irq_o, 0);
    rd_exp(CT, 8'h00, "R1 ctrl");
    rd_exp(CF, 8'h00, "R1 cfg");
    rd_exp(VL, 8'h00, "R1 vlo");
    rd_exp(VH, 8'h00, "R1 vhi");
    rd_exp(8'h10, 8'h00, "R13 unmapped");

    // R2 seconds, R10 pulses, R11 irq line 3
    wr(CF, 8'hD3);
    rd_exp(CF, 8'hD3, "R13 cfg readback");
    wr(VH, 8'h00); wr(VL, 8'h05);
    ticks(4);
    rd_exp(CT, 8'h00, "R2 before N");
    check("R11 irq idle", irq_o, 0);
    ticks(1);
    check("R10 kbd start", kbd_rst_o, 1);
    check("R10 pwr start", pwr_drop_o, 1);
    check("R11 irq sel3", irq_o, 16'h0008);
    n = 0;
    while (kbd_rst_o && n < 100) begin n++; @(negedge clk); end
    check("R10 width", n, 16);
    check("R10 pwr end", pwr_drop_o, 0);
    rd_exp(CT, 8'h01, "R2 expired");

    // R12 no re-expiry
    wr(CT, 8'h00);
    ticks(8);
    rd_exp(CT, 8'h00, "R12 no refire");
    check("R12 kbd quiet", kbd_rst_o, 0);

    // R8 force, R9 sticky
    wr(CT, 8'h02);
    rd_exp(CT, 8'h01, "R8 forced, bit1 reads 0");
    wr(CT, 8'h01);
    rd_exp(CT, 8'h01, "R9 write 1 keeps flag");
    wr(CT, 8'h00);
    rd_exp(CT, 8'h00, "R9 write 0 clears");

    // R4 MSB alone does not load
    wr(CF, 8'h80);
    wr(VH, 8'h01);
    ticks(3);
    rd_exp(CT, 8'h00, "R4 MSB no load");
    wr(VL, 8'h00);
    rd_exp(VH, 8'h01, "R4 vhi readback");
    ticks(255);
    rd_exp(CT, 8'h00, "R4 256 not yet");
    ticks(1);
    rd_exp(CT, 8'h01, "R4 256 expiry");
    wr(CT, 8'h00);

    // R5 zero stops
    wr(VH, 8'h00); wr(VL, 8'h00);
    ticks(10);
    rd_exp(CT, 8'h00, "R5 stopped");

    // R3 minute units
    wr(CF, 8'h00);
    wr(VL, 8'h02);
    ticks(119);
    rd_exp(CT, 8'h00, "R3 119 ticks");
    ticks(1);
    rd_exp(CT, 8'h01, "R3 120 ticks");
    check("R11 sel0 none", irq_o, 0);
    wr(CT, 8'h00);
    wr(VL, 8'h02);
    ticks(30);
    wr(VL, 8'h02);
    ticks(119);
    rd_exp(CT, 8'h00, "R3 divider restart");
    ticks(1);
    rd_exp(CT, 8'h01, "R3 after restart");

    // R6 event reload
    wr(CF, 8'h80);
    wr(CT, 8'h10);
    wr(VL, 8'h03);
    ticks(2);
    @(negedge clk); ev_game = 1; @(negedge clk); ev_game = 0;
    ticks(2);
    rd_exp(CT, 8'h10, "R6 game reload");
    ticks(1);
    rd_exp(CT, 8'h11, "R6 game then expiry");
    wr(CT, 8'h00);
    wr(VL, 8'h03);
    ticks(2);
    @(negedge clk); ev_game = 1; @(negedge clk); ev_game = 0;
    ticks(1);
    rd_exp(CT, 8'h01, "R6 disabled game ignored");
    wr(CT, 8'h60);
    wr(VL, 8'h03);
    ticks(2);
    @(negedge clk); ev_kbd = 1; @(negedge clk); ev_kbd = 0;
    ticks(2);
    @(negedge clk); ev_mouse = 1; @(negedge clk); ev_mouse = 0;
    ticks(2);
    rd_exp(CT, 8'h60, "R6 kbd and mouse reload");
    ticks(1);
    rd_exp(CT, 8'h61, "R6 kbd/mouse expiry");

    // R7 delayed IR reload
    wr(CT, 8'h80);
    wr(VL, 8'h03);
    ticks(2);
    @(negedge clk); ev_ir = 1; @(negedge clk); ev_ir = 0;
    ticks(1);
    rd_exp(CT, 8'h81, "R7 reload not yet effective");
    repeat (20) @(negedge clk);
    wr(CT, 8'h80);
    wr(VL, 8'h03);
    ticks(2);
    @(negedge clk); ev_ir = 1; @(negedge clk); ev_ir = 0;
    repeat (12) @(negedge clk);
    ticks(2);
    rd_exp(CT, 8'h80, "R7 reload after delay");
    ticks(1);
    rd_exp(CT, 8'h81, "R7 expiry after reload");

    repeat (4) @(negedge clk);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule